// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor Core

This block is a 16-bit single-accumulator processor. A 16-entry control store sequences it. Every microword drives a small datapath with three buses. Two source buses, A and B, are summed by one adder. The adder's result bus is the only path into the architectural registers and into main memory.

The registers are the instruction register, the accumulator, a 10-bit fetch pointer and a 10-bit memory pointer. A 1024-word main memory sits inside the block and reads combinationally. Reset loads it with a built-in test program.

The block has no data inputs. Its outputs are debug taps that show the micro-address and the registers. A write-event stream reports each memory store as valid, address and data. That stream has no ready: it carries no back-pressure, and each valid beat lasts exactly one cycle.

Top module: `mcode_acc_cpu`

## Requirements
- R1: While `rst_n` is low, the micro-address, fetch pointer, memory pointer, instruction register and accumulator all read zero.
- R2: An instruction is fetched by micro-words 0 to 3, one per cycle, in this order:
  - word 0 copies the fetch pointer into the memory pointer;
  - word 1 adds one to the fetch pointer;
  - word 2 loads the instruction register from memory at the memory pointer;
  - word 3 copies the low 10 bits of the instruction register into the memory pointer.
- R3: An instruction word holds the opcode in bits 15:10 and the operand address in bits 9:0. After word 3 the micro-address is taken from the opcode as follows:
  - 4 (load) goes to 4;
  - 8 (store) goes to 5;
  - 16 (add) goes to 6;
  - 33 (branch if non-negative) goes to 7;
  - 32 (branch) goes to 8.
- R4: Load copies memory at the memory pointer into the accumulator.
- R5: Add replaces the accumulator with the accumulator plus memory at the memory pointer, modulo 2^16. The carry-out is dropped.
- R6: Store writes the accumulator to memory at the memory pointer. The write appears on the debug write stream for exactly that one cycle, and the accumulator is left unchanged.
- R7: Branch loads the fetch pointer from the operand address.
- R8: Branch-if-non-negative runs word 7. If accumulator bit 15 is 0, control passes to word 8 and the branch is taken. If the bit is 1, control passes to word 9, which changes nothing.
- R9: Every execute micro-word (4, 5, 6, 8 and 9) is followed by micro-word 0.
- R10: An opcode outside the five listed sends word 3 straight back to word 0. Apart from the fetch steps, no register changes.
- R11: In the built-in program, load 20, add 21, store 30 with word 20 = 7 and word 21 = 9 writes 0x0010 to word 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also reloads memory |
| dbg_upc | output | 4 | Current micro-address |
| dbg_iar | output | 10 | Fetch pointer |
| dbg_mar | output | 10 | Memory pointer |
| dbg_ir | output | 16 | Instruction register |
| dbg_acc | output | 16 | Accumulator |
| dbg_wr_valid | output | 1 | A memory store happens this cycle |
| dbg_wr_addr | output | 10 | Store address |
| dbg_wr_data | output | 16 | Stored data |

## Verification
The only inputs are clock and reset, so the assertions assume that reset is held low across at least one rising edge. The rest of the behaviour follows from the built-in program. The stimulus is a single reset pulse followed by free running.

The program is arranged so that it covers all of the following:
- both outcomes of the conditional branch;
- an unconditional branch;
- an unknown opcode;
- an add that wraps to zero.

The store stream is compared against a queue of expected writes.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int DW  = 16;
  localparam int AW  = 10;
  localparam int OPW = DW - AW;
  localparam int UAW = 4;

  typedef struct packed {
    logic           src_ir;
    logic           ld_ir;
    logic           src_acc;
    logic           ld_acc;
    logic           src_iar;
    logic           ld_iar;
    logic           ld_mar;
    logic           rd;
    logic           wr;
    logic           one;
    logic           sel_op;
    logic           cond;
    logic [UAW-1:0] nxt;
  } uword_t;

  localparam logic [OPW-1:0] OP_LD  = 6'd4;
  localparam logic [OPW-1:0] OP_ST  = 6'd8;
  localparam logic [OPW-1:0] OP_ADD = 6'd16;
  localparam logic [OPW-1:0] OP_JMP = 6'd32;
  localparam logic [OPW-1:0] OP_JNN = 6'd33;

  function automatic uword_t ucode(input logic [UAW-1:0] a);
    uword_t w;
    w = '0;
    case (a)
      4'd0: begin w.src_iar = 1'b1; w.ld_mar = 1'b1; w.nxt = 4'd1; end
      4'd1: begin w.src_iar = 1'b1; w.ld_iar = 1'b1; w.one = 1'b1; w.nxt = 4'd2; end
      4'd2: begin w.ld_ir = 1'b1; w.rd = 1'b1; w.nxt = 4'd3; end
      4'd3: begin w.src_ir = 1'b1; w.ld_mar = 1'b1; w.sel_op = 1'b1; end
      4'd4: begin w.ld_acc = 1'b1; w.rd = 1'b1; end
      4'd5: begin w.src_acc = 1'b1; w.wr = 1'b1; end
      4'd6: begin w.src_acc = 1'b1; w.ld_acc = 1'b1; w.rd = 1'b1; end
      4'd7: begin w.cond = 1'b1; w.nxt = 4'd8; end
      4'd8: begin w.src_ir = 1'b1; w.ld_iar = 1'b1; end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [UAW-1:0] op_entry(input logic [OPW-1:0] op);
    case (op)
      OP_LD:   return 4'd4;
      OP_ST:   return 4'd5;
      OP_ADD:  return 4'd6;
      OP_JNN:  return 4'd7;
      OP_JMP:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [DW-1:0] boot_word(input int unsigned a);
    case (a)
      0:  return {OP_LD,  10'd20};
      1:  return {OP_ADD, 10'd21};
      2:  return {OP_ST,  10'd30};
      3:  return {OP_JNN, 10'd6};
      4:  return {OP_ST,  10'd31};
      6:  return {OP_LD,  10'd22};
      7:  return {OP_JNN, 10'd4};
      8:  return {OP_ADD, 10'd23};
      9:  return {OP_ST,  10'd32};
      10: return {OP_ADD, 10'd24};
      11: return {OP_ST,  10'd33};
      12: return {OP_JMP, 10'd15};
      13: return {OP_ST,  10'd31};
      15: return {6'd63,  10'd5};
      16: return {OP_ADD, 10'd25};
      17: return {OP_ST,  10'd34};
      18: return {OP_JMP, 10'd18};
      20: return 16'h0007;
      21: return 16'h0009;
      22: return 16'h8000;
      23: return 16'h8000;
      24: return 16'hFFFF;
      25: return 16'h0001;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mac_useq.sv
`timescale 1ns/1ps
module mac_useq
  import mac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  input  logic           acc_neg,
  output logic [UAW-1:0] upc,
  output uword_t         uw
);
  logic [UAW-1:0] upc_nxt;

  always_comb begin
    uw = ucode(upc);
    if (uw.sel_op) upc_nxt = op_entry(op);
    else           upc_nxt = uw.nxt | {{(UAW-1){1'b0}}, uw.cond & acc_neg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= '0;
    else        upc <= upc_nxt;
  end
endmodule

// File: rtl/mac_mem.sv
`timescale 1ns/1ps
module mac_mem
  import mac_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW,
  localparam int DEPTH = 1 << ADDR_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(boot_word(i));
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/mac_datapath.sv
`timescale 1ns/1ps
module mac_datapath
  import mac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_ir,
  input  logic          src_acc,
  input  logic          src_iar,
  input  logic          rd,
  input  logic          one,
  input  logic          ld_ir,
  input  logic          ld_acc,
  input  logic          ld_iar,
  input  logic          ld_mar,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cbus,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] iar,
  output logic [AW-1:0] mar
);
  logic [DW-1:0] abus, bbus;

  always_comb begin
    abus = ({DW{src_ir}}  & ir)
         | ({DW{src_acc}} & acc)
         | ({DW{src_iar}} & {{OPW{1'b0}}, iar});
    bbus = ({DW{rd}}  & mem_rdata)
         | ({DW{one}} & DW'(1));
    cbus = abus + bbus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir  <= '0;
      acc <= '0;
      iar <= '0;
      mar <= '0;
    end else begin
      if (ld_ir)  ir  <= cbus;
      if (ld_acc) acc <= cbus;
      if (ld_iar) iar <= cbus[AW-1:0];
      if (ld_mar) mar <= cbus[AW-1:0];
    end
  end
endmodule

// File: rtl/mcode_acc_cpu.sv
`timescale 1ns/1ps
module mcode_acc_cpu
  import mac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic [3:0]    dbg_upc,
  output logic [9:0]    dbg_iar,
  output logic [9:0]    dbg_mar,
  output logic [15:0]   dbg_ir,
  output logic [15:0]   dbg_acc,
  output logic          dbg_wr_valid,
  output logic [9:0]    dbg_wr_addr,
  output logic [15:0]   dbg_wr_data
);
  uword_t        uw;
  logic [UAW-1:0] upc;
  logic [DW-1:0] cbus, ir, acc, mem_rdata;
  logic [AW-1:0] iar, mar;

  mac_useq u_seq (
    .clk(clk), .rst_n(rst_n),
    .op(ir[DW-1:AW]), .acc_neg(acc[DW-1]),
    .upc(upc), .uw(uw)
  );

  mac_datapath u_dp (
    .clk(clk), .rst_n(rst_n),
    .src_ir(uw.src_ir), .src_acc(uw.src_acc), .src_iar(uw.src_iar),
    .rd(uw.rd), .one(uw.one),
    .ld_ir(uw.ld_ir), .ld_acc(uw.ld_acc), .ld_iar(uw.ld_iar), .ld_mar(uw.ld_mar),
    .mem_rdata(mem_rdata), .cbus(cbus),
    .ir(ir), .acc(acc), .iar(iar), .mar(mar)
  );

  mac_mem #(.ADDR_W(AW), .DATA_W(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(uw.wr), .addr(mar), .wdata(cbus), .rdata(mem_rdata)
  );

  assign dbg_upc      = upc;
  assign dbg_iar      = iar;
  assign dbg_mar      = mar;
  assign dbg_ir       = ir;
  assign dbg_acc      = acc;
  assign dbg_wr_valid = uw.wr;
  assign dbg_wr_addr  = mar;
  assign dbg_wr_data  = cbus;
endmodule

// File: rtl/mcode_acc_cpu_chk.sv
`timescale 1ns/1ps
module mcode_acc_cpu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  upc,
  input logic [9:0]  iar,
  input logic [15:0] acc,
  input logic        wr_valid,
  input logic [15:0] wr_data
);
  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd0) |=> (upc == 4'd1));
  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd1) |=> (iar == $past(iar) + 10'd1));
  // R3
  dispatch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd3) |=> (upc inside {4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8}));
  // R8
  jnn_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd7 && !acc[15]) |=> (upc == 4'd8));
  // R8
  jnn_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd7 && acc[15]) |=> (upc == 4'd9 && $stable(iar)));
  // R9
  exec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc inside {4'd4, 4'd5, 4'd6, 4'd8, 4'd9}) |=> (upc == 4'd0));
  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (upc == 4'd5 && wr_data == acc));
  // R6
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd5) |=> $stable(acc));
endmodule

bind mcode_acc_cpu mcode_acc_cpu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upc(dbg_upc), .iar(dbg_iar), .acc(dbg_acc),
  .wr_valid(dbg_wr_valid), .wr_data(dbg_wr_data)
);

// File: tb/mcode_acc_cpu_tb_top.sv
`timescale 1ns/1ps
module mcode_acc_cpu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  dbg_upc;
  logic [9:0]  dbg_iar, dbg_mar, dbg_wr_addr;
  logic [15:0] dbg_ir, dbg_acc, dbg_wr_data;
  logic        dbg_wr_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [25:0] exp_q [$];

  always #4 clk = ~clk;

  mcode_acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n),
    .dbg_upc(dbg_upc), .dbg_iar(dbg_iar), .dbg_mar(dbg_mar),
    .dbg_ir(dbg_ir), .dbg_acc(dbg_acc),
    .dbg_wr_valid(dbg_wr_valid), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic expect_write(input logic [9:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // scoreboard monitor for the store stream (R6, R11)
  always @(negedge clk) begin
    if (rst_n && dbg_wr_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected store", {6'd0, dbg_wr_addr, dbg_wr_data}, 32'd0);
      end else begin
        logic [25:0] e;
        e = exp_q.pop_front();
        check({dbg_wr_addr, dbg_wr_data} == e, "R6/R11 store", {6'd0, dbg_wr_addr, dbg_wr_data}, {6'd0, e});
      end
    end
  end

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    expect_write(10'd30, 16'h0010); // R11
    expect_write(10'd32, 16'h0000);
    expect_write(10'd33, 16'hFFFF);
    expect_write(10'd34, 16'h0000);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dbg_upc == 0 && dbg_iar == 0 && dbg_mar == 0, "R1 pointers", {dbg_upc, dbg_iar, dbg_mar}, 32'd0);
    check(dbg_ir == 0 && dbg_acc == 0, "R1 ir/acc", {dbg_ir, dbg_acc}, 32'd0);
    rst_n = 1'b1;
    wait_to(1); check(dbg_upc == 1 && dbg_mar == 0, "R2 word0", {dbg_upc, dbg_mar}, {4'd1, 10'd0});
    wait_to(2); check(dbg_upc == 2 && dbg_iar == 1, "R2 word1", {dbg_upc, dbg_iar}, {4'd2, 10'd1});
    wait_to(3); check(dbg_ir == 16'h1014, "R2 word2", dbg_ir, 16'h1014);
    wait_to(4); check(dbg_upc == 4 && dbg_mar == 20, "R3 load dispatch", {dbg_upc, dbg_mar}, {4'd4, 10'd20});
    wait_to(5); check(dbg_upc == 0 && dbg_acc == 7, "R4 R9 load", {dbg_upc, dbg_acc}, {4'd0, 16'd7});
    wait_to(9); check(dbg_upc == 6, "R3 add dispatch", dbg_upc, 6);
    wait_to(10); check(dbg_acc == 16'h0010, "R5 add", dbg_acc, 16'h0010);
    wait_to(14); check(dbg_upc == 5, "R3 store dispatch", dbg_upc, 5);
    wait_to(15); check(dbg_acc == 16'h0010, "R6 acc kept", dbg_acc, 16'h0010);
    wait_to(19); check(dbg_upc == 7, "R3 jnn dispatch", dbg_upc, 7);
    wait_to(20); check(dbg_upc == 8, "R8 taken path", dbg_upc, 8);
    wait_to(21); check(dbg_iar == 6, "R8 taken target", dbg_iar, 6);
    wait_to(26); check(dbg_acc == 16'h8000, "R4 negative load", dbg_acc, 16'h8000);
    wait_to(31); check(dbg_upc == 9, "R8 not taken path", dbg_upc, 9);
    wait_to(32); check(dbg_upc == 0 && dbg_iar == 8, "R8 R9 fall through", {dbg_upc, dbg_iar}, {4'd0, 10'd8});
    wait_to(37); check(dbg_acc == 16'h0000, "R5 wrap", dbg_acc, 0);
    wait_to(47); check(dbg_acc == 16'hFFFF, "R5 add ffff", dbg_acc, 16'hFFFF);
    wait_to(56); check(dbg_upc == 8, "R3 jmp dispatch", dbg_upc, 8);
    wait_to(57); check(dbg_iar == 15, "R7 branch", dbg_iar, 15);
    wait_to(61); check(dbg_upc == 0 && dbg_iar == 16 && dbg_mar == 5, "R10 unknown opcode", {dbg_upc, dbg_iar, dbg_mar}, {4'd0, 10'd16, 10'd5});
    check(dbg_acc == 16'hFFFF, "R10 acc kept", dbg_acc, 16'hFFFF);
    wait_to(66); check(dbg_acc == 16'h0000, "R5 wrap from ffff", dbg_acc, 0);
    wait_to(116); check(dbg_iar == 18 && dbg_upc == 0, "R7 self loop", {dbg_upc, dbg_iar}, {4'd0, 10'd18});
    check(exp_q.size() == 0, "R6 all stores seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule